// File: doc/BRIEF.md
# Contended Memory Wait-State Generator

This block sits beside the CPU of a 48K home computer and decides how long a CPU memory access has to wait while the video logic is fetching from the shared RAM. A t-state counter runs on the CPU clock. It is forced back to position 0 by the frame interrupt and also wraps on its own at the end of a frame. A second tracker follows where the beam is inside the contended window: which display line it is on, and which column of that line.

When the CPU issues a memory request into the 16 KB shared window at 0x4000..0x7FFF during a fetch slot, the block works out a delay of 0 to 6 t-states. That delay depends on the slot's place inside an 8-t-state group. The block then raises a stall output for exactly that many t-states. The t-state counter keeps running while the stall is raised.

A one-bit variant select moves the whole contention pattern one t-state later. This covers the two machine revisions that differ in this way.

Top module: `contention_waitgen`

## Requirements
- R1: Only a request whose address lies in 0x4000..0x7FFF (inclusive) can be delayed. Any other address gives `delay_o` = 0 and never raises `stall_o`.
- R2: The cycle in which `frame_irq_i` is high is t-state 0. The next cycle is t-state 1, and so on. Every pulse resynchronises the count, even in the middle of a frame.
- R3: The first contended t-state is FIRST_POS when `late_variant_i` = 0 and FIRST_POS+1 when it is 1. A window access at that t-state gets a delay of 6. An access one t-state before it gets a delay of 0.
- R4: Take k as the number of t-states past the start of the current display line, modulo 8. The delay for k = 0,1,2,3,4,5,6,7 is 6,5,4,3,2,1,0,0.
- R5: Display lines start every LINE_LEN t-states from the first contended t-state, for ACTIVE_LINES lines. Only the first FETCH_LEN t-states of each line are contended. Everywhere else the delay is 0.
- R6: Without an interrupt, the counter wraps from FRAME_LEN-1 to 0. The contention window then occurs again at the same positions.
- R7: An accepted access with delay D raises `stall_o` for exactly D consecutive cycles, beginning the cycle after the access. An access with D = 0 does not raise it.
- R8: A request made while `stall_o` is high is not accepted. In that case `delay_o` = 0 and the stall is not extended. The t-state counter advances during a stall, so once the stall ends the delay follows the advanced position.
- R9: Reset sets the counter to t-state 0 and clears `stall_o` at once, even in the middle of a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock, one t-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_irq_i | input | 1 | Frame interrupt pulse; marks t-state 0 |
| mreq_i | input | 1 | CPU memory request in this t-state |
| addr_i | input | 16 | CPU address bus |
| late_variant_i | input | 1 | 1 moves the contention pattern one t-state later |
| stall_o | output | 1 | Holds the CPU while high |
| delay_o | output | 3 | Delay computed for the request in this t-state |

## Verification
The main instance is built with a 600-t-state frame, 24-t-state lines, 16 fetch t-states per line, 4 display lines and the first contended position at 100. With these values the bench can reach, in a few hundred cycles each, the end of a fetch run, the step from one line to the next, the end of the last display line and a frame wrap. A second instance keeps the default full-size values, so the bench can also confirm that the first contended position lands on 14335 or 14336 depending on the variant select.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

    typedef logic [2:0] delay_t;

    // Delay for a column whose position within its 8-t-state group is k.
    function automatic delay_t slot_delay(input logic [2:0] k);
        return (k < 3'd6) ? delay_t'(3'd6 - k) : 3'd0;
    endfunction

endpackage

// File: rtl/cwg_tstate_counter.sv
module cwg_tstate_counter #(
    parameter int FRAME_LEN = 69888,
    parameter int CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_i,
    output logic [CNT_W-1:0] pos_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        pos_o = irq_i ? '0 : s_q.cnt;
        s_d   = s_q;
        if (pos_o == CNT_W'(FRAME_LEN - 1))
            s_d.cnt = '0;
        else
            s_d.cnt = pos_o + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, s_q.cnt} < (CNT_W+1)'(FRAME_LEN));

    // R2
    irq_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> (s_q.cnt == CNT_W'(1)));

    // R6
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_i && s_q.cnt == CNT_W'(FRAME_LEN - 1)) |=> (s_q.cnt == '0));

endmodule

// File: rtl/cwg_beam_tracker.sv
module cwg_beam_tracker
    import cwg_pkg::*;
#(
    parameter int CNT_W        = 17,
    parameter int FIRST_POS    = 14335,
    parameter int LINE_LEN     = 224,
    parameter int FETCH_LEN    = 128,
    parameter int ACTIVE_LINES = 192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_i,
    input  logic [CNT_W-1:0] pos_i,
    input  logic             late_i,
    output delay_t           raw_delay_o
);

    localparam int COL_W  = $clog2(LINE_LEN);
    localparam int LINE_W = $clog2(ACTIVE_LINES) + 1;

    typedef struct packed {
        logic              active;
        logic [COL_W-1:0]  col;
        logic [LINE_W-1:0] line;
    } beam_state_t;

    beam_state_t s_d, s_q;

    logic [CNT_W-1:0]  first;
    logic              start, act, col_end, last_line;
    logic [COL_W-1:0]  col_c;
    logic [LINE_W-1:0] line_c;

    always_comb begin
        first     = CNT_W'(FIRST_POS) + CNT_W'(late_i);
        start     = !irq_i && (pos_i == first);
        act       = !irq_i && (s_q.active || start);
        col_c     = start ? '0 : s_q.col;
        line_c    = start ? '0 : s_q.line;
        col_end   = (col_c == COL_W'(LINE_LEN - 1));
        last_line = (line_c == LINE_W'(ACTIVE_LINES - 1));

        s_d = '0;
        if (act) begin
            s_d.col    = col_end ? '0 : col_c + 1'b1;
            s_d.line   = col_end ? line_c + 1'b1 : line_c;
            s_d.active = !(col_end && last_line);
        end

        if (act && (col_c < COL_W'(FETCH_LEN)))
            raw_delay_o = slot_delay(col_c[2:0]);
        else
            raw_delay_o = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3
    window_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.active) |-> ($past(pos_i) == $past(first)));

    // R2
    window_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> !s_q.active);

    // R5
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.col < COL_W'(LINE_LEN));

endmodule

// File: rtl/cwg_stall_ctrl.sv
module cwg_stall_ctrl
    import cwg_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BASE = 'h4000,
    parameter int WIN_SIZE = 'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mreq_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  delay_t            raw_delay_i,
    output logic              stall_o,
    output delay_t            delay_o
);

    localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(WIN_BASE);
    localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(WIN_BASE + WIN_SIZE);

    typedef struct packed {
        delay_t left;
    } stall_state_t;

    stall_state_t s_d, s_q;
    logic in_win, take;

    always_comb begin
        in_win  = ({1'b0, addr_i} >= WIN_LO) && ({1'b0, addr_i} < WIN_HI);
        stall_o = (s_q.left != '0);
        take    = mreq_i && in_win && !stall_o;
        delay_o = take ? raw_delay_i : '0;
        s_d     = s_q;
        if (stall_o) s_d.left = s_q.left - 1'b1;
        else         s_d.left = delay_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7
    stall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_i && in_win && !stall_o && raw_delay_i != '0) |=> stall_o);

    // R7
    no_zero_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_i && in_win && !stall_o && raw_delay_i == '0) |=> !stall_o);

    // R1
    outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && !(mreq_i && in_win)) |=> !stall_o);

    // R8
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (delay_o == '0));

endmodule

// File: rtl/contention_waitgen.sv
module contention_waitgen
    import cwg_pkg::*;
#(
    parameter int FRAME_LEN    = 69888,
    parameter int FIRST_POS    = 14335,
    parameter int LINE_LEN     = 224,
    parameter int FETCH_LEN    = 128,
    parameter int ACTIVE_LINES = 192,
    parameter int ADDR_W       = 16,
    parameter int WIN_BASE     = 'h4000,
    parameter int WIN_SIZE     = 'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_irq_i,
    input  logic              mreq_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              late_variant_i,
    output logic              stall_o,
    output logic [2:0]        delay_o
);

    localparam int CNT_W = $clog2(FRAME_LEN);

    logic [CNT_W-1:0] pos;
    delay_t           raw_delay;

    cwg_tstate_counter #(
        .FRAME_LEN (FRAME_LEN),
        .CNT_W     (CNT_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .irq_i (frame_irq_i),
        .pos_o (pos)
    );

    cwg_beam_tracker #(
        .CNT_W        (CNT_W),
        .FIRST_POS    (FIRST_POS),
        .LINE_LEN     (LINE_LEN),
        .FETCH_LEN    (FETCH_LEN),
        .ACTIVE_LINES (ACTIVE_LINES)
    ) u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (frame_irq_i),
        .pos_i       (pos),
        .late_i      (late_variant_i),
        .raw_delay_o (raw_delay)
    );

    cwg_stall_ctrl #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE)
    ) u_stall (
        .clk         (clk),
        .rst_n       (rst_n),
        .mreq_i      (mreq_i),
        .addr_i      (addr_i),
        .raw_delay_i (raw_delay),
        .stall_o     (stall_o),
        .delay_o     (delay_o)
    );

endmodule

// File: tb/tb_contention_waitgen.sv
module tb_contention_waitgen;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [15:0] pos;
        logic        late;
        logic [15:0] addr;
        logic [2:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    // Small build: frame 600, first contended t-state 100, line 24, fetch 16, 4 lines.
    localparam vec_t VECS [NV] = '{
        '{16'd100, 1'b0, 16'h4000, 3'd6, 4'd3},  // R3 first slot
        '{16'd101, 1'b0, 16'h5000, 3'd5, 4'd4},  // R4
        '{16'd102, 1'b0, 16'h6123, 3'd4, 4'd4},
        '{16'd103, 1'b0, 16'h4000, 3'd3, 4'd4},
        '{16'd104, 1'b0, 16'h4000, 3'd2, 4'd4},
        '{16'd105, 1'b0, 16'h7FFF, 3'd1, 4'd4},  // R1 top of window
        '{16'd106, 1'b0, 16'h4000, 3'd0, 4'd4},
        '{16'd107, 1'b0, 16'h4000, 3'd0, 4'd4},
        '{16'd108, 1'b0, 16'h4000, 3'd6, 4'd4},  // next group
        '{16'd99,  1'b0, 16'h4000, 3'd0, 4'd3},  // before window
        '{16'd100, 1'b1, 16'h4000, 3'd0, 4'd3},  // late variant
        '{16'd101, 1'b1, 16'h4000, 3'd6, 4'd3},
        '{16'd102, 1'b1, 16'h4000, 3'd5, 4'd3},
        '{16'd113, 1'b0, 16'h4000, 3'd1, 4'd4},
        '{16'd116, 1'b0, 16'h4000, 3'd0, 4'd5},  // R5 past fetch run
        '{16'd123, 1'b0, 16'h4000, 3'd0, 4'd5},
        '{16'd124, 1'b0, 16'h4000, 3'd6, 4'd5},  // line 1 start
        '{16'd172, 1'b0, 16'h4000, 3'd6, 4'd5},  // last line start
        '{16'd181, 1'b0, 16'h4000, 3'd5, 4'd5},
        '{16'd196, 1'b0, 16'h4000, 3'd0, 4'd5},  // after last line
        '{16'd100, 1'b0, 16'h3FFF, 3'd0, 4'd1},  // R1 below window
        '{16'd100, 1'b0, 16'h8000, 3'd0, 4'd1},  // above window
        '{16'd101, 1'b0, 16'hC000, 3'd0, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic        mreq = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        late = 1'b0;
    logic        dut_stall, def_stall;
    logic [2:0]  dut_delay, def_delay;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    contention_waitgen #(
        .FRAME_LEN    (600),
        .FIRST_POS    (100),
        .LINE_LEN     (24),
        .FETCH_LEN    (16),
        .ACTIVE_LINES (4)
    ) dut (
        .clk (clk), .rst_n (rst_n), .frame_irq_i (irq), .mreq_i (mreq),
        .addr_i (addr), .late_variant_i (late),
        .stall_o (dut_stall), .delay_o (dut_delay)
    );

    contention_waitgen dut_def (
        .clk (clk), .rst_n (rst_n), .frame_irq_i (irq), .mreq_i (mreq),
        .addr_i (addr), .late_variant_i (late),
        .stall_o (def_stall), .delay_o (def_delay)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Pulse the interrupt, then stop at the negedge where the position is p (p >= 1).
    task automatic goto_pos(input int p, input logic l);
        @(negedge clk);
        irq = 1'b1; mreq = 1'b0; late = l;
        repeat (p) begin
            @(negedge clk);
            irq = 1'b0;
        end
    endtask

    task automatic stall_len(output int n);
        n = 0;
        while (dut_stall && n < 12) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        // R9 reset state, request active during reset
        mreq = 1'b1; addr = 16'h4000;
        repeat (3) @(negedge clk);
        chk("R9 stall in reset", int'(dut_stall), 0);
        chk("R9 delay in reset", int'(dut_delay), 0);
        mreq = 1'b0;
        rst_n = 1'b1;
        // R9 counter starts at 0 after reset: 100 cycles later is the first slot
        repeat (100) @(negedge clk);
        mreq = 1'b1; #1;
        chk("R9 counter from reset", int'(dut_delay), 6);
        @(negedge clk); mreq = 1'b0;
        chk("R7 stall after access", int'(dut_stall), 1);
        rst_n = 1'b0; #1;
        chk("R9 reset clears stall", int'(dut_stall), 0);
        @(negedge clk); rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            goto_pos(int'(VECS[i].pos), VECS[i].late);
            mreq = 1'b1; addr = VECS[i].addr; #1;
            chk($sformatf("R%0d vector %0d delay", VECS[i].req, i),
                int'(dut_delay), int'(VECS[i].exp));
            @(negedge clk); mreq = 1'b0;
            stall_len(n);
            chk($sformatf("R7 vector %0d stall length", i), n, int'(VECS[i].exp));
        end

        // R8 request held through a stall
        goto_pos(100, 1'b0);
        mreq = 1'b1; addr = 16'h4000;
        n = 0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk); #1;
            if (dut_stall) n++;
            if (i == 3) chk("R8 delay during stall", int'(dut_delay), 0);
        end
        chk("R8 stall not extended", n, 6);
        chk("R8 counter advanced in stall", int'(dut_delay), 6);
        @(negedge clk); mreq = 1'b0;
        repeat (8) @(negedge clk);

        // R2 mid-frame resync
        goto_pos(60, 1'b0);
        goto_pos(100, 1'b0);
        mreq = 1'b1; #1;
        chk("R2 resync mid-frame", int'(dut_delay), 6);
        @(negedge clk); mreq = 1'b0;
        repeat (8) @(negedge clk);

        // R6 frame wrap without interrupt
        goto_pos(700, 1'b0);
        mreq = 1'b1; #1;
        chk("R6 window after wrap", int'(dut_delay), 6);
        @(negedge clk); mreq = 1'b0;
        repeat (8) @(negedge clk);

        // R3 full-size positions
        goto_pos(14334, 1'b0);
        mreq = 1'b1; #1;
        chk("R3 default 14334", int'(def_delay), 0);
        @(negedge clk); mreq = 1'b0;
        goto_pos(14335, 1'b0);
        mreq = 1'b1; #1;
        chk("R3 default 14335", int'(def_delay), 6);
        @(negedge clk); mreq = 1'b0;
        goto_pos(14335, 1'b1);
        mreq = 1'b1; #1;
        chk("R3 late 14335", int'(def_delay), 0);
        @(negedge clk); mreq = 1'b0;
        goto_pos(14336, 1'b1);
        mreq = 1'b1; #1;
        chk("R3 late 14336", int'(def_delay), 6);
        @(negedge clk); mreq = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule